// File: doc/BRIEF.md
# USB OTG Power and Clock-Gating Controller

This block is the power-management control logic for a USB on-the-go core. Software programs a small register file. It holds a transceiver power-on control and two VBUS-comparator enables, one for the host-side comparators and one for the device-side comparators. It also holds two clock-gating controls: one stops the internal USB clock domain and one gates the internal system clock domain. The block drives one clock-enable output for each of those domains. The register interface and the wake detector run on an always-on clock and are never gated.

The block also sequences a system-stop state. Stop can be entered only while the USB link is suspended and the USB clock has already been stopped. A deep-sleep request that arrives in any other situation does not move the controller. Line activity on the bus is resume signalling in device mode and remote-wakeup signalling in host mode. This activity arrives asynchronously, passes through a synchronizer, and wakes the block. The wake clears both gating controls, leaves stop, restores both clock enables and sets a sticky wake flag. Software clears that flag by writing 1 to it.

Top module: `usb_pwr_ctl`

## Requirements
- R1: After reset all register bits read 0, `in_stop`, `wake_irq` and `sleep_err` are 0, and both `usb_clk_en` and `sys_clk_en` are 1.
- R2: The register map is as follows. Address 0 (configuration): bit 0 powers the transceiver on, bit 1 is the software host-sense enable, bit 2 is the software device-sense enable. Address 1 (gating): bit 0 stops the USB clock, bit 1 gates the system clock. Address 2 (status): bit 0 is the wake flag, bit 1 is the sleep error, bit 2 is the stop state (read only). Unused bits and address 3 read 0. Reads are combinational from `rd_addr`.
- R3: `session_go` equals `session_req` AND the transceiver power-on bit. A session request made while that bit is clear is held off.
- R4: `host_sense_en` is 1 whenever `host_mode` or `hnp_active` is 1, or when the software host-sense bit is set.
- R5: `dev_sense_en` is 1 whenever `host_mode` is 0 (device mode) or `hnp_active` is 1, or when the software device-sense bit is set.
- R6: The clock enables are registered. They reflect the gating register at the same clock edge that writes it: `usb_clk_en` = NOT stop-USB-clock bit and `sys_clk_en` = NOT gate-system-clock bit, and both are 0 while `in_stop` is 1.
- R7: A `sleep_req` sampled at an edge while the controller is running, `suspended` is 1 and the stop-USB-clock bit is set makes the controller enter stop at that edge: `in_stop` goes to 1 and both enables go to 0.
- R8: A `sleep_req` made while the stop-USB-clock bit is clear is ignored: state and enables are unchanged and `sleep_err` is set. A request made while not suspended is ignored and raises no error.
- R9: A rising edge on `line_act_async` passes through SYNC_STAGES flops (2 by default). It acts at edge SYNC_STAGES+1 after the input rises, and only if the controller is in stop or either gating bit is set. The wake leaves stop, clears both gating bits, restores both enables and sets `wake_irq`. Otherwise the edge is ignored.
- R10: Writing 1 to status bit 0 or bit 1 clears that flag. If a set and a clear of the same flag fall in one cycle, the set wins.
- R11: A wake takes priority over a gating-register write and over a sleep acceptance in the same cycle. The gating bits end at 0 and the controller stays running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | DATA_W | Read data |
| session_req | input | 1 | Request to start a USB session |
| session_go | output | 1 | Session start permitted |
| host_mode | input | 1 | 1 = host, 0 = device |
| hnp_active | input | 1 | Host negotiation in progress |
| phy_pwr_en | output | 1 | Transceiver power on |
| host_sense_en | output | 1 | Host-side VBUS comparator enable |
| dev_sense_en | output | 1 | Device-side VBUS comparator enable |
| suspended | input | 1 | USB link is suspended |
| sleep_req | input | 1 | Deep-sleep request |
| line_act_async | input | 1 | Asynchronous bus activity (resume/remote wakeup) |
| in_stop | output | 1 | Controller is in system stop |
| usb_clk_en | output | 1 | USB clock domain enable |
| sys_clk_en | output | 1 | System clock domain enable |
| wake_irq | output | 1 | Sticky wake flag |
| sleep_err | output | 1 | Sticky rejected-sleep flag |

## Verification
A synchronized wake edge can land in the same cycle as a software write to the gating register, as a sleep acceptance, or as a write-1-to-clear of the wake flag. The bench raises the line input and counts the synchronizer edges, so that the chosen write or sleep pulse is driven into exactly the cycle in which the wake acts. It then judges the outcome at the ports. The gating register must read 0, both enables must be 1, `in_stop` must be 0 and the wake flag must still be set.

// File: rtl/usb_pwr_pkg.sv
package usb_pwr_pkg;

  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_CFG  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_GATE = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd2;

  // field positions inside the registers
  localparam int CFG_XCVR_ON  = 0;
  localparam int CFG_HOST_SNS = 1;
  localparam int CFG_DEV_SNS  = 2;
  localparam int GATE_STOP    = 0;
  localparam int GATE_SYS     = 1;
  localparam int STAT_WAKE    = 0;
  localparam int STAT_ERR     = 1;
  localparam int STAT_STOP    = 2;

  typedef enum logic {
    PS_RUN  = 1'b0,
    PS_STOP = 1'b1
  } pwr_state_e;

  // returns {sys_en, usb_en}
  function automatic logic [1:0] clk_en_f(pwr_state_e st, logic stop_b, logic gate_b);
    logic run;
    run = (st == PS_RUN);
    return {run && !gate_b, run && !stop_b};
  endfunction

  function automatic logic host_sense_f(logic sw, logic host, logic hnp);
    return sw || host || hnp;
  endfunction

  function automatic logic dev_sense_f(logic sw, logic host, logic hnp);
    return sw || !host || hnp;
  endfunction

endpackage

// File: rtl/usb_pwr_wake_sync.sv
module usb_pwr_wake_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic edge_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], async_in};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign edge_o = sync_q[STAGES-1] && !prev_q;
endmodule

// File: rtl/usb_pwr_regs.sv
module usb_pwr_regs
  import usb_pwr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              restore,
  input  logic              wake_set,
  input  logic              err_set,
  input  logic              in_stop,
  output logic              xcvr_on,
  output logic              host_sw,
  output logic              dev_sw,
  output logic              stop_q,
  output logic              gate_q,
  output logic              stop_nxt,
  output logic              gate_nxt,
  output logic              wake_flag,
  output logic              sleep_err
);
  logic [2:0] cfg_q;
  logic       wake_nxt, err_nxt;
  logic       wr_cfg, wr_gate, wr_stat;
  logic       unused_hi;

  assign unused_hi = ^wr_data[DATA_W-1:3];

  assign wr_cfg  = wr_en && (wr_addr == ADDR_CFG);
  assign wr_gate = wr_en && (wr_addr == ADDR_GATE);
  assign wr_stat = wr_en && (wr_addr == ADDR_STAT);

  // gating bits: a wake overrides a same-cycle write
  always_comb begin
    stop_nxt = stop_q;
    gate_nxt = gate_q;
    if (wr_gate) begin
      stop_nxt = wr_data[GATE_STOP];
      gate_nxt = wr_data[GATE_SYS];
    end
    if (restore) begin
      stop_nxt = 1'b0;
      gate_nxt = 1'b0;
    end
  end

  // sticky flags: set beats write-1-to-clear
  always_comb begin
    wake_nxt = wake_flag;
    err_nxt  = sleep_err;
    if (wr_stat && wr_data[STAT_WAKE]) wake_nxt = 1'b0;
    if (wr_stat && wr_data[STAT_ERR])  err_nxt  = 1'b0;
    if (wake_set) wake_nxt = 1'b1;
    if (err_set)  err_nxt  = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q     <= '0;
      stop_q    <= 1'b0;
      gate_q    <= 1'b0;
      wake_flag <= 1'b0;
      sleep_err <= 1'b0;
    end else begin
      if (wr_cfg) cfg_q <= wr_data[2:0];
      stop_q    <= stop_nxt;
      gate_q    <= gate_nxt;
      wake_flag <= wake_nxt;
      sleep_err <= err_nxt;
    end
  end

  assign xcvr_on = cfg_q[CFG_XCVR_ON];
  assign host_sw = cfg_q[CFG_HOST_SNS];
  assign dev_sw  = cfg_q[CFG_DEV_SNS];

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      ADDR_CFG:  rd_data[2:0] = cfg_q;
      ADDR_GATE: begin
        rd_data[GATE_STOP] = stop_q;
        rd_data[GATE_SYS]  = gate_q;
      end
      ADDR_STAT: begin
        rd_data[STAT_WAKE] = wake_flag;
        rd_data[STAT_ERR]  = sleep_err;
        rd_data[STAT_STOP] = in_stop;
      end
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/usb_pwr_seq.sv
module usb_pwr_seq
  import usb_pwr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic stop_q,
  input  logic gate_q,
  input  logic stop_nxt,
  input  logic gate_nxt,
  input  logic suspended,
  input  logic sleep_req,
  input  logic wake_edge,
  output logic in_stop,
  output logic accept,
  output logic reject,
  output logic restore,
  output logic usb_clk_en,
  output logic sys_clk_en
);
  pwr_state_e st_q, st_nxt;
  logic [1:0] en_q;

  assign restore = wake_edge && ((st_q == PS_STOP) || stop_q || gate_q);
  assign accept  = sleep_req && (st_q == PS_RUN) && suspended && stop_q && !restore;
  assign reject  = sleep_req && (st_q == PS_RUN) && !stop_q;

  always_comb begin
    st_nxt = st_q;
    if (restore)     st_nxt = PS_RUN;
    else if (accept) st_nxt = PS_STOP;
  end

  // enables are loaded from next-state values, so they flip only on an edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= PS_RUN;
      en_q <= 2'b11;
    end else begin
      st_q <= st_nxt;
      en_q <= clk_en_f(st_nxt, stop_nxt, gate_nxt);
    end
  end

  assign in_stop    = (st_q == PS_STOP);
  assign usb_clk_en = en_q[0];
  assign sys_clk_en = en_q[1];
endmodule

// File: rtl/usb_pwr_ctl.sv
module usb_pwr_ctl
  import usb_pwr_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              session_req,
  output logic              session_go,
  input  logic              host_mode,
  input  logic              hnp_active,
  output logic              phy_pwr_en,
  output logic              host_sense_en,
  output logic              dev_sense_en,
  input  logic              suspended,
  input  logic              sleep_req,
  input  logic              line_act_async,
  output logic              in_stop,
  output logic              usb_clk_en,
  output logic              sys_clk_en,
  output logic              wake_irq,
  output logic              sleep_err
);
  logic xcvr_on, host_sw, dev_sw;
  logic stop_q, gate_q, stop_nxt, gate_nxt;
  logic wake_edge, accept, reject, restore;

  usb_pwr_wake_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(line_act_async), .edge_o(wake_edge)
  );

  usb_pwr_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .restore(restore), .wake_set(restore), .err_set(reject), .in_stop(in_stop),
    .xcvr_on(xcvr_on), .host_sw(host_sw), .dev_sw(dev_sw),
    .stop_q(stop_q), .gate_q(gate_q), .stop_nxt(stop_nxt), .gate_nxt(gate_nxt),
    .wake_flag(wake_irq), .sleep_err(sleep_err)
  );

  usb_pwr_seq u_seq (
    .clk(clk), .rst_n(rst_n),
    .stop_q(stop_q), .gate_q(gate_q), .stop_nxt(stop_nxt), .gate_nxt(gate_nxt),
    .suspended(suspended), .sleep_req(sleep_req), .wake_edge(wake_edge),
    .in_stop(in_stop), .accept(accept), .reject(reject), .restore(restore),
    .usb_clk_en(usb_clk_en), .sys_clk_en(sys_clk_en)
  );

  assign phy_pwr_en    = xcvr_on;
  assign session_go    = session_req && xcvr_on;
  assign host_sense_en = host_sense_f(host_sw, host_mode, hnp_active);
  assign dev_sense_en  = dev_sense_f(dev_sw, host_mode, hnp_active);
endmodule

// File: rtl/usb_pwr_ctl_chk.sv
module usb_pwr_ctl_chk (
  input logic clk,
  input logic rst_n,
  input logic session_req,
  input logic session_go,
  input logic phy_pwr_en,
  input logic host_mode,
  input logic hnp_active,
  input logic host_sense_en,
  input logic dev_sense_en,
  input logic suspended,
  input logic sleep_req,
  input logic stop_q,
  input logic wake_edge,
  input logic in_stop,
  input logic usb_clk_en,
  input logic sys_clk_en,
  input logic wake_irq,
  input logic sleep_err
);
  assert_session_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    session_go |-> (phy_pwr_en && session_req));

  assert_host_sense_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (host_mode || hnp_active) |-> host_sense_en);

  assert_dev_sense_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_mode || hnp_active) |-> dev_sense_en);

  assert_stop_gates_usb_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stop_q |-> !usb_clk_en);

  assert_stop_gates_both_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_stop |-> (!usb_clk_en && !sys_clk_en));

  assert_stop_entry_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_stop) |-> ($past(sleep_req) && $past(suspended) && $past(stop_q)));

  assert_reject_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sleep_err) |-> ($past(sleep_req) && !$past(stop_q)));

  assert_stop_exit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_stop) |-> $past(wake_edge));

  assert_wake_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_irq) |-> $past(wake_edge));
endmodule

bind usb_pwr_ctl usb_pwr_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n),
  .session_req(session_req), .session_go(session_go), .phy_pwr_en(phy_pwr_en),
  .host_mode(host_mode), .hnp_active(hnp_active),
  .host_sense_en(host_sense_en), .dev_sense_en(dev_sense_en),
  .suspended(suspended), .sleep_req(sleep_req),
  .stop_q(stop_q), .wake_edge(wake_edge),
  .in_stop(in_stop), .usb_clk_en(usb_clk_en), .sys_clk_en(sys_clk_en),
  .wake_irq(wake_irq), .sleep_err(sleep_err)
);

// File: tb/usb_pwr_ctl_tb.sv
`timescale 1ns/1ps
module usb_pwr_ctl_tb;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [1:0] rd_addr = '0;
  logic [DW-1:0] rd_data;
  logic session_req = 1'b0, host_mode = 1'b0, hnp_active = 1'b0;
  logic suspended = 1'b0, sleep_req = 1'b0, line_act_async = 1'b0;
  logic session_go, phy_pwr_en, host_sense_en, dev_sense_en;
  logic in_stop, usb_clk_en, sys_clk_en, wake_irq, sleep_err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  usb_pwr_ctl #(.DATA_W(DW), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .session_req(session_req),
    .session_go(session_go), .host_mode(host_mode), .hnp_active(hnp_active),
    .phy_pwr_en(phy_pwr_en), .host_sense_en(host_sense_en), .dev_sense_en(dev_sense_en),
    .suspended(suspended), .sleep_req(sleep_req), .line_act_async(line_act_async),
    .in_stop(in_stop), .usb_clk_en(usb_clk_en), .sys_clk_en(sys_clk_en),
    .wake_irq(wake_irq), .sleep_err(sleep_err)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic rd_chk(input string tag, input logic [1:0] a, input logic [DW-1:0] exp);
    rd_addr = a;
    #1;
    chk(tag, rd_data, exp);
  endtask

  task automatic pulse_sleep();
    sleep_req = 1'b1;
    @(negedge clk);
    sleep_req = 1'b0;
  endtask

  // enables expected from the gating value and stop state
  task automatic en_chk(input string tag, input logic [1:0] g, input logic stop);
    chk({tag, " usb_en"}, usb_clk_en, !stop && !g[0]);
    chk({tag, " sys_en"}, sys_clk_en, !stop && !g[1]);
  endtask

  task automatic line_drop();
    line_act_async = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 in_stop", in_stop, 0);
    chk("R1 wake_irq", wake_irq, 0);
    chk("R1 sleep_err", sleep_err, 0);
    en_chk("R1", 2'b00, 1'b0);
    for (int a = 0; a < 4; a++) rd_chk("R1 reg", a[1:0], '0);

    // R2 unused bits read zero
    wr(2'd0, 8'hFF);
    rd_chk("R2 cfg mask", 2'd0, 8'h07);
    wr(2'd3, 8'hFF);
    rd_chk("R2 addr3", 2'd3, 8'h00);

    // R3 R4 R5 sweep over configuration and mode inputs
    for (int c = 0; c < 8; c++) begin
      wr(2'd0, DW'(c));
      rd_chk("R2 cfg readback", 2'd0, DW'(c));
      for (int m = 0; m < 8; m++) begin
        host_mode = m[0]; hnp_active = m[1]; session_req = m[2];
        #1;
        chk("R3 session_go", session_go, m[2] & c[0]);
        chk("R3 phy_pwr_en", phy_pwr_en, c[0]);
        chk("R4 host_sense", host_sense_en, c[1] | m[0] | m[1]);
        chk("R5 dev_sense", dev_sense_en, c[2] | !m[0] | m[1]);
      end
    end
    host_mode = 1'b0; hnp_active = 1'b0; session_req = 1'b0;
    @(negedge clk);

    // R6 gating sweep
    for (int g = 0; g < 4; g++) begin
      wr(2'd1, DW'(g));
      en_chk("R6", g[1:0], 1'b0);
      rd_chk("R2 gate readback", 2'd1, DW'(g));
    end

    // R8 sleep while USB clock running: ignored with error
    wr(2'd1, 8'h00);
    suspended = 1'b1;
    pulse_sleep();
    chk("R8 no stop", in_stop, 0);
    en_chk("R8", 2'b00, 1'b0);
    chk("R8 err set", sleep_err, 1);
    rd_chk("R8 stat", 2'd2, 8'h02);
    wr(2'd2, 8'h02);
    chk("R10 err cleared", sleep_err, 0);

    // R8 not suspended: ignored, no error
    wr(2'd1, 8'h01);
    suspended = 1'b0;
    pulse_sleep();
    chk("R8 unsuspended no stop", in_stop, 0);
    chk("R8 unsuspended no err", sleep_err, 0);
    en_chk("R8 unsuspended", 2'b01, 1'b0);

    // R7 legal entry
    suspended = 1'b1;
    pulse_sleep();
    chk("R7 in_stop", in_stop, 1);
    en_chk("R7", 2'b01, 1'b1);
    rd_chk("R7 stat", 2'd2, 8'h04);

    // R9 wake from stop with latency
    line_act_async = 1'b1;
    repeat (2) @(negedge clk);
    chk("R9 not yet", in_stop, 1);
    @(negedge clk);
    chk("R9 left stop", in_stop, 0);
    en_chk("R9", 2'b00, 1'b0);
    chk("R9 wake flag", wake_irq, 1);
    rd_chk("R9 gate cleared", 2'd1, 8'h00);
    line_drop();
    wr(2'd2, 8'h01);
    chk("R10 wake cleared", wake_irq, 0);

    // R9 edge while nothing gated is ignored
    line_act_async = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 idle ignored", wake_irq, 0);
    line_drop();

    // R9 wake in run with only system clock gated
    wr(2'd1, 8'h02);
    en_chk("R6 sys gated", 2'b10, 1'b0);
    line_act_async = 1'b1;
    repeat (3) @(negedge clk);
    en_chk("R9 sys restore", 2'b00, 1'b0);
    chk("R9 sys wake flag", wake_irq, 1);
    line_drop();

    // R11 + R10: wake collides with a write-1-to-clear of the wake flag
    wr(2'd1, 8'h01);
    line_act_async = 1'b1;
    repeat (2) @(negedge clk);
    wr(2'd2, 8'h01);
    chk("R10 set wins", wake_irq, 1);
    rd_chk("R11 gate cleared", 2'd1, 8'h00);
    line_drop();
    wr(2'd2, 8'h01);

    // R11: wake collides with a gating write
    wr(2'd1, 8'h01);
    line_act_async = 1'b1;
    repeat (2) @(negedge clk);
    wr(2'd1, 8'h03);
    rd_chk("R11 write loses", 2'd1, 8'h00);
    en_chk("R11 write", 2'b00, 1'b0);
    line_drop();

    // R11: wake collides with an otherwise legal sleep request
    wr(2'd1, 8'h01);
    line_act_async = 1'b1;
    repeat (2) @(negedge clk);
    pulse_sleep();
    chk("R11 sleep loses", in_stop, 0);
    en_chk("R11 sleep", 2'b00, 1'b0);
    line_drop();

    finish_run();
  end
endmodule